// File: doc/BRIEF.md
# XOR-Coded Two-Write Two-Read Memory

This block is a small word-addressed memory that serves two writers and two readers in every clock cycle. There is no arbitration and no stalling. Each access has its own address. The block contains no true multi-port storage. Every storage bank it uses has one write port and one combinational read port.

The two write ports each own a bank group. On a write, a port stores its data XOR-ed with the other group's current word at the same address. A read at an address XOR-combines the two groups' words, which yields the last value written there by either port.

Each group holds three identical copies of its banks:
- one copy for each read port;
- one copy used by the opposite write port when it encodes.

Reads are combinational. A read returns the stored contents as they stand before the coming clock edge. A write becomes visible from the next cycle.

When both ports write one address in the same cycle, the block raises a collision output. A parameter picks what happens to the stored word in that case:
- In the raw mode both encoded writes land. The word at that address is then unspecified until it is written again.
- In the drop mode the write from port 1 is discarded, and port 0's data is kept.

The default geometry is 128 words of 8 bits with a 7-bit address, and all of it is set by parameters.

Top module: `xmem_2w2r`

## Requirements
- R1: After reset every address reads as zero on both read ports.
- R2: A word written through write port 0 reads back on either read port from the cycle after the write.
- R3: A word written through write port 1 reads back on either read port from the cycle after the write.
- R4: Two writes in one cycle to different addresses are both stored.
- R5: The two read ports work independently in the same cycle. This holds at any pair of addresses, equal ones included, and each port returns the word last written at its address.
- R6: A read at an address that is being written in the same cycle returns the contents from before that write.
- R7: While a read port's enable is low, its data output is all zeros.
- R8: The collision output is high in exactly those cycles where both write enables are high and both write addresses are equal. It is combinational and valid in the same cycle.
- R9: In the raw mode (`COLL_MODE` = 0, the default) a collision leaves the collided address unspecified until its next write. All other addresses are unaffected.
- R10: In the drop mode (`COLL_MODE` = 1), on a collision the word from write port 0 is stored and the word from write port 1 is discarded.
- R11: With no write to an address, its contents stay unchanged across any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears every bank |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | AW | Write port 0 address |
| wr0_data | input | DW | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | AW | Write port 1 address |
| wr1_data | input | DW | Write port 1 data |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_addr | input | AW | Read port 0 address |
| rd0_data | output | DW | Read port 0 data, zero when disabled |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_addr | input | AW | Read port 1 address |
| rd1_data | output | DW | Read port 1 data, zero when disabled |
| collide | output | 1 | Both write ports address one word in this cycle |

## Verification
Read data and the collision flag are due in the same cycle as their inputs. Written words are due one rising edge after the write.

The bench drives every input on the falling edge. One time unit later it compares the read data and the collision flag with a model that still holds the pre-edge contents. It updates that model only after the rising edge, so a read of a word being written is checked against its old value. The new value is checked in the following cycle.

Two instances run the same stimulus, one in raw mode and one in drop mode. The model tracks which addresses a raw-mode collision has left unspecified and skips them until they are rewritten.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    // Behaviour on a same-address double write
    typedef enum logic [0:0] {
        XM_COLL_RAW   = 1'b0,   // both encoded writes land, word unspecified
        XM_COLL_DROP1 = 1'b1    // port 1 write discarded, port 0 data kept
    } xm_coll_e;

endpackage

// File: rtl/xmem_bank.sv
// One storage bank: a single write port and a single combinational read port.
module xmem_bank #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R2
    bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/xmem_group.sv
// A bank group: NCOPY identical banks written together, each with its own reader.
module xmem_group #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    parameter int AW    = 7,
    parameter int NCOPY = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [DW-1:0]              wdata,
    input  logic [NCOPY-1:0][AW-1:0]   raddr,
    output logic [NCOPY-1:0][DW-1:0]   rdata
);

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        xmem_bank #(
            .DEPTH (DEPTH),
            .DW    (DW),
            .AW    (AW)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we),
            .waddr (waddr),
            .wdata (wdata),
            .raddr (raddr[c]),
            .rdata (rdata[c])
        );
    end

    // All copies hold the same contents, so two copies at one address agree.
    if (NCOPY > 1) begin : g_agree
        // R11
        copy_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (raddr[0] == raddr[1]) |-> (rdata[0] == rdata[1]));
    end

endmodule

// File: rtl/xmem_collide.sv
// Same-address detection and the write-enable policy chosen by MODE.
module xmem_collide
    import xmem_pkg::*;
#(
    parameter int       AW   = 7,
    parameter xm_coll_e MODE = XM_COLL_RAW
) (
    input  logic          we0,
    input  logic          we1,
    input  logic [AW-1:0] a0,
    input  logic [AW-1:0] a1,
    output logic          collide,
    output logic          we0_eff,
    output logic          we1_eff
);

    assign collide = we0 & we1 & (a0 == a1);
    assign we0_eff = we0;

    if (MODE == XM_COLL_DROP1) begin : g_drop
        assign we1_eff = we1 & ~collide;
    end else begin : g_raw
        assign we1_eff = we1;
    end

endmodule

// File: rtl/xmem_2w2r.sv
// Two-write two-read memory built from single-port banks with XOR coding.
module xmem_2w2r
    import xmem_pkg::*;
#(
    parameter int       DEPTH     = 128,
    parameter int       DW        = 8,
    parameter int       AW        = $clog2(DEPTH),
    parameter xm_coll_e COLL_MODE = XM_COLL_RAW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr0_en,
    input  logic [AW-1:0] wr0_addr,
    input  logic [DW-1:0] wr0_data,
    input  logic          wr1_en,
    input  logic [AW-1:0] wr1_addr,
    input  logic [DW-1:0] wr1_data,
    input  logic          rd0_en,
    input  logic [AW-1:0] rd0_addr,
    output logic [DW-1:0] rd0_data,
    input  logic          rd1_en,
    input  logic [AW-1:0] rd1_addr,
    output logic [DW-1:0] rd1_data,
    output logic          collide
);

    localparam int NRD   = 2;        // read ports
    localparam int NCOPY = NRD + 1;  // one copy per reader plus the encode copy
    localparam int ENC   = NRD;      // index of the encode copy

    logic                     we0_eff, we1_eff;
    logic [NCOPY-1:0][AW-1:0] g0_ra, g1_ra;
    logic [NCOPY-1:0][DW-1:0] g0_rd, g1_rd;
    logic [DW-1:0]            g0_wd, g1_wd;
    logic                     rd_en_a   [NRD];
    logic [DW-1:0]            rd_data_a [NRD];

    xmem_collide #(
        .AW   (AW),
        .MODE (COLL_MODE)
    ) u_coll (
        .we0     (wr0_en),
        .we1     (wr1_en),
        .a0      (wr0_addr),
        .a1      (wr1_addr),
        .collide (collide),
        .we0_eff (we0_eff),
        .we1_eff (we1_eff)
    );

    // The encode copy of each group is read at the other port's write address.
    assign g0_ra = {wr1_addr, rd1_addr, rd0_addr};
    assign g1_ra = {wr0_addr, rd1_addr, rd0_addr};

    assign g0_wd = wr0_data ^ g1_rd[ENC];
    assign g1_wd = wr1_data ^ g0_rd[ENC];

    xmem_group #(
        .DEPTH (DEPTH), .DW (DW), .AW (AW), .NCOPY (NCOPY)
    ) u_grp0 (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we0_eff),
        .waddr (wr0_addr),
        .wdata (g0_wd),
        .raddr (g0_ra),
        .rdata (g0_rd)
    );

    xmem_group #(
        .DEPTH (DEPTH), .DW (DW), .AW (AW), .NCOPY (NCOPY)
    ) u_grp1 (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we1_eff),
        .waddr (wr1_addr),
        .wdata (g1_wd),
        .raddr (g1_ra),
        .rdata (g1_rd)
    );

    assign rd_en_a[0] = rd0_en;
    assign rd_en_a[1] = rd1_en;

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data_a[r] = rd_en_a[r] ? (g0_rd[r] ^ g1_rd[r]) : '0;
    end

    assign rd0_data = rd_data_a[0];
    assign rd1_data = rd_data_a[1];

    // R8
    coll_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide |-> (wr0_en && wr1_en));

    // R2, R10
    rd_after_wr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en && (!collide || COLL_MODE == XM_COLL_DROP1)) |=>
        (!rd0_en || rd0_addr != $past(wr0_addr) || rd0_data == $past(wr0_data)));

    // R3
    rd_after_wr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1_en && !collide) |=>
        (!rd1_en || rd1_addr != $past(wr1_addr) || rd1_data == $past(wr1_data)));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_en && $past(rd0_en) && rd0_addr == $past(rd0_addr) &&
         !($past(we0_eff) && $past(wr0_addr) == rd0_addr) &&
         !($past(we1_eff) && $past(wr1_addr) == rd0_addr)) |-> $stable(rd0_data));

endmodule

// File: tb/xmem_2w2r_tb.sv
module xmem_2w2r_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 128;
    localparam int DW         = 8;
    localparam int AW         = 7;
    localparam int WATCHDOG   = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr0_en = 1'b0, wr1_en = 1'b0, rd0_en = 1'b0, rd1_en = 1'b0;
    logic [AW-1:0] wr0_addr = '0, wr1_addr = '0, rd0_addr = '0, rd1_addr = '0;
    logic [DW-1:0] wr0_data = '0, wr1_data = '0;
    logic [DW-1:0] r0_raw, r1_raw, r0_drp, r1_drp;
    logic          c_raw, c_drp;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Model: raw-mode contents with a known flag, drop-mode contents
    logic [DW-1:0] mem_m [DEPTH];
    bit            known [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_2w2r dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
        .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(r0_raw),
        .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(r1_raw),
        .collide(c_raw)
    );

    xmem_2w2r #(.COLL_MODE(xmem_pkg::XM_COLL_DROP1)) dut_drop_i (
        .clk(clk), .rst_n(rst_n),
        .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
        .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(r0_drp),
        .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(r1_drp),
        .collide(c_drp)
    );

    function automatic bit exp_coll(bit e0, bit e1, logic [AW-1:0] a0, logic [AW-1:0] a1);
        return e0 && e1 && (a0 == a1);
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_port(string req, bit en, logic [AW-1:0] a,
                            logic [DW-1:0] act_raw, logic [DW-1:0] act_drp);
        if (!en) begin
            chk("R7", act_raw, '0);
            chk("R7", act_drp, '0);
        end else begin
            if (known[a]) chk(req, act_raw, mem_m[a]);
            chk(req, act_drp, mem_d[a]);
        end
    endtask

    task automatic verify(string req);
        chk_port(req, rd0_en, rd0_addr, r0_raw, r0_drp);
        chk_port(req, rd1_en, rd1_addr, r1_raw, r1_drp);
        chk("R8", {7'd0, c_raw}, {7'd0, exp_coll(wr0_en, wr1_en, wr0_addr, wr1_addr)});
        chk("R8", {7'd0, c_drp}, {7'd0, exp_coll(wr0_en, wr1_en, wr0_addr, wr1_addr)});
    endtask

    task automatic update_model();
        if (exp_coll(wr0_en, wr1_en, wr0_addr, wr1_addr)) begin
            known[wr0_addr] = 1'b0;
            mem_d[wr0_addr] = wr0_data;
        end else begin
            if (wr0_en) begin
                mem_m[wr0_addr] = wr0_data; known[wr0_addr] = 1'b1;
                mem_d[wr0_addr] = wr0_data;
            end
            if (wr1_en) begin
                mem_m[wr1_addr] = wr1_data; known[wr1_addr] = 1'b1;
                mem_d[wr1_addr] = wr1_data;
            end
        end
    endtask

    task automatic cycle(bit e0, logic [AW-1:0] a0, logic [DW-1:0] d0,
                         bit e1, logic [AW-1:0] a1, logic [DW-1:0] d1,
                         bit re0, logic [AW-1:0] ra0,
                         bit re1, logic [AW-1:0] ra1, string req);
        @(negedge clk);
        wr0_en = e0; wr0_addr = a0; wr0_data = d0;
        wr1_en = e1; wr1_addr = a1; wr1_data = d1;
        rd0_en = re0; rd0_addr = ra0; rd1_en = re1; rd1_addr = ra1;
        #1;
        verify(req);
        @(posedge clk);
        update_model();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_m[i] = '0; known[i] = 1'b1; mem_d[i] = '0;
        end
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every address reads zero after reset, both ports
        for (int i = 0; i < DEPTH; i += 2)
            cycle(0, 0, 0, 0, 0, 0, 1, AW'(i), 1, AW'(i + 1), "R1");

        // R6 then R2: port 0 write, same-cycle read sees old value
        cycle(1, 7'd5, 8'hA5, 0, 0, 0, 1, 7'd5, 1, 7'd5, "R6");
        cycle(0, 0, 0, 0, 0, 0, 1, 7'd5, 1, 7'd5, "R2");
        // R3: port 1 write
        cycle(0, 0, 0, 1, 7'd9, 8'h3C, 1, 7'd9, 0, 0, "R6");
        cycle(0, 0, 0, 0, 0, 0, 1, 7'd9, 1, 7'd9, "R3");
        // R4: both write different addresses in one cycle
        cycle(1, 7'd3, 8'h11, 1, 7'd4, 8'h22, 0, 0, 0, 0, "R4");
        cycle(0, 0, 0, 0, 0, 0, 1, 7'd3, 1, 7'd4, "R4");
        cycle(0, 0, 0, 0, 0, 0, 1, 7'd4, 1, 7'd3, "R5");
        // R4: overwrite through the other ports
        cycle(1, 7'd4, 8'h5E, 1, 7'd3, 8'hE5, 1, 7'd3, 1, 7'd4, "R4");
        cycle(0, 0, 0, 0, 0, 0, 1, 7'd3, 1, 7'd4, "R4");
        // R7: disabled reads give zero even at written addresses
        cycle(0, 0, 0, 0, 0, 0, 0, 7'd3, 0, 7'd4, "R7");
        // R11: hold over idle cycles
        cycle(1, 7'd30, 8'h77, 0, 0, 0, 0, 0, 0, 0, "R11");
        for (int k = 0; k < 6; k++)
            cycle(0, 0, 0, 0, 0, 0, 1, 7'd30, 1, 7'd5, "R11");

        // R8/R9/R10: collision at address 20, neighbour 21
        cycle(1, 7'd20, 8'h10, 1, 7'd21, 8'h21, 0, 0, 0, 0, "R4");
        cycle(1, 7'd20, 8'hAA, 1, 7'd20, 8'h55, 1, 7'd20, 0, 0, "R8");
        cycle(0, 0, 0, 0, 0, 0, 1, 7'd20, 1, 7'd21, "R10");
        cycle(0, 0, 0, 0, 0, 0, 1, 7'd21, 1, 7'd21, "R9");
        cycle(0, 0, 0, 1, 7'd20, 8'h66, 0, 0, 0, 0, "R9");
        cycle(0, 0, 0, 0, 0, 0, 1, 7'd20, 1, 7'd20, "R9");
        // R8: equal addresses with one enable low is not a collision
        cycle(1, 7'd40, 8'h01, 0, 7'd40, 8'h02, 0, 0, 0, 0, "R8");
        cycle(0, 7'd40, 8'h03, 1, 7'd40, 8'h04, 1, 7'd40, 0, 0, "R8");
        cycle(0, 0, 0, 0, 0, 0, 1, 7'd40, 1, 7'd40, "R3");

        // R5: random mix, addresses often in a small window to force hits
        for (int n = 0; n < 4000; n++) begin
            bit narrow;
            logic [AW-1:0] a0, a1, ra0, ra1;
            narrow = ($urandom % 2) == 0;
            a0  = narrow ? AW'($urandom % 16) : AW'($urandom % DEPTH);
            a1  = narrow ? AW'($urandom % 16) : AW'($urandom % DEPTH);
            ra0 = narrow ? AW'($urandom % 16) : AW'($urandom % DEPTH);
            ra1 = narrow ? AW'($urandom % 16) : AW'($urandom % DEPTH);
            cycle(($urandom % 10) < 6, a0, DW'($urandom),
                  ($urandom % 10) < 6, a1, DW'($urandom),
                  ($urandom % 10) < 8, ra0,
                  ($urandom % 10) < 8, ra1, "R5");
        end

        finish_run();
    end

endmodule